// File: doc/BRIEF.md
# Serial PHY PLL Setting Calculator

This block turns a requested per-lane bit rate, given in Mbps, into the two settings a serial-link PLL needs. The first is a 3-bit post-divider rate code. The second is a 15-bit feedback divider word made of a 5-bit integer part and a 10-bit fraction. The caller pulses `start_i` with the rate on `lane_mbps_i` and waits for the one-cycle `done_o` pulse. When that pulse arrives the result is on the outputs, and `err_o` tells whether the request could be met.

The calculator first searches for the smallest power-of-two multiplier that brings the VCO (lane rate × 2^code) up to at least 1600 MHz. It then divides the VCO by the 192 MHz feedback comparison step, which is eight times a 24 MHz reference. One restoring shift-subtract divider produces the integer quotient and the fraction rounded to the nearest 1/1024 in a single pass. The block rejects three kinds of request: a rate of zero, a rate above the 4000 MHz VCO ceiling, and a rate that would need a code above 4.

Top module: `pll_setting_calc`

## Requirements
- R1: A start with a lane rate of 0 is rejected: `done_o` and `err_o` are both 1 right after the clock edge that samples the start.
- R2: A start with a lane rate above 4000 is rejected in the same way, right after the sampling edge.
- R3: For a rate from 1 to 4000, the rate code is the smallest r in 0..4 for which rate × 2^r ≥ 1600. If no such r exists (rates 1 to 99), the request is rejected.
- R4: On success, `fb_div_o` equals floor((rate × 2^r × 1024 + 96) / 192). Its bits [14:10] hold floor(VCO / 192) and its bits [9:0] hold the rounded fraction.
- R5: After a rejected request, `rate_code_o` and `fb_div_o` both read 0.
- R6: Latency, counting the edge that samples `start_i` as edge 1, is fixed. A rejection for zero or too high a rate lands after edge 1. A rejection for too low a rate lands after edge 6. A success with code r lands after edge r + 25.
- R7: `done_o` is high for exactly one cycle. `err_o`, `rate_code_o` and `fb_div_o` keep their values until the next result is delivered.
- R8: `busy_o` is 1 from the edge after an accepted start until the result is delivered. A start seen while `busy_o` is 1 is ignored and does not change the pending result.
- R9: During reset, `busy_o`, `done_o`, `err_o`, `rate_code_o` and `fb_div_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a calculation; sampled only while idle |
| lane_mbps_i | input | 13 | Requested lane rate in Mbps |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| err_o | output | 1 | Last request was rejected |
| rate_code_o | output | 3 | Post-divider rate code (VCO = rate × 2^code) |
| fb_div_o | output | 15 | Feedback divider: integer in [14:10], fraction in [9:0] |

## Verification
The bench works out the expected result for each request on its own. For each request it also works out the exact edge on which `done_o` must appear: edge 1 for zero or over-ceiling rates, edge 6 for rates below 100, and edge r + 25 for accepted rates. It counts rising edges from the one that samples `start_i` and samples the outputs 1 ns after each edge. The check fails if `done_o` arrives on any other edge. It covers every rate from 0 to 4100 plus the top input code. One edge after each result it checks that `done_o` has dropped and that the outputs have held. A separate run sends a second start in mid-calculation and checks that the first result is delivered unchanged at its original time.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SCALE  = 2'd1,
      ST_DIVIDE = 2'd2
   } calc_state_e;

endpackage

// File: rtl/pllcfg_octave_search.sv
// Doubles the VCO candidate one step per cycle and tracks the rate code.
module pllcfg_octave_search #(
   parameter int VCO_W    = 12,
   parameter int RATE_W   = 3,
   parameter int VCO_MIN  = 1600,
   parameter int MAX_RATE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [VCO_W-1:0]  seed_i,
   output logic [VCO_W-1:0]  vco_o,
   output logic [RATE_W-1:0] rate_o,
   output logic              reached_o,
   output logic              exhausted_o
);

   localparam logic [VCO_W-1:0]  VCO_FLOOR = VCO_W'(VCO_MIN);
   localparam logic [RATE_W-1:0] RATE_TOP  = RATE_W'(MAX_RATE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vco_o  <= '0;
         rate_o <= '0;
      end else if (load_i) begin
         vco_o  <= seed_i;
         rate_o <= '0;
      end else if (step_i) begin
         vco_o  <= {vco_o[VCO_W-2:0], 1'b0};
         rate_o <= rate_o + 1'b1;
      end
   end

   assign reached_o   = (vco_o >= VCO_FLOOR);
   assign exhausted_o = (rate_o == RATE_TOP);

endmodule

// File: rtl/pllcfg_restoring_div.sv
// Restoring shift-subtract divider by a constant; DIVD_W cycles per result.
module pllcfg_restoring_div #(
   parameter int DIVD_W  = 22,
   parameter int DIVISOR = 192,
   parameter int QUOT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DIVD_W-1:0] dividend_i,
   output logic [QUOT_W-1:0] quot_o,
   output logic              fin_o
);

   localparam int REM_W = $clog2(DIVISOR + 1);
   localparam int CNT_W = $clog2(DIVD_W + 1);
   localparam logic [REM_W:0]   DIVISOR_V = (REM_W+1)'(DIVISOR);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIVD_W - 1);

   if (QUOT_W > DIVD_W) begin : g_bad_quot
      $error("quotient wider than dividend");
   end
   if (DIVISOR < 2) begin : g_bad_divisor
      $error("divisor must be at least 2");
   end

   logic [DIVD_W-1:0] acc_q;
   logic [REM_W-1:0]  rem_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;
   logic [REM_W:0]    trial;
   logic [REM_W:0]    diff;
   logic              fits;
   logic [REM_W-1:0]  rem_next;

   always_comb begin
      trial    = {rem_q, acc_q[DIVD_W-1]};
      diff     = trial - DIVISOR_V;
      fits     = (trial >= DIVISOR_V);
      rem_next = fits ? diff[REM_W-1:0] : trial[REM_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         rem_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
         fin_o    <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (load_i) begin
            acc_q    <= dividend_i;
            rem_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b1;
         end else if (active_q) begin
            acc_q <= {acc_q[DIVD_W-2:0], fits};
            rem_q <= rem_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_STEP) begin
               active_q <= 1'b0;
               fin_o    <= 1'b1;
            end
         end
      end
   end

   assign quot_o = acc_q[QUOT_W-1:0];

endmodule

// File: rtl/pll_setting_calc.sv
module pll_setting_calc #(
   parameter int LANE_W        = 13,
   parameter int REF_MHZ       = 24,
   parameter int FB_MULT       = 8,
   parameter int VCO_MIN       = 1600,
   parameter int VCO_MAX       = 4000,
   parameter int MAX_RATE      = 4,
   parameter int RATE_W        = 3,
   parameter int INT_W         = 5,
   parameter int FRAC_W        = 10,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [LANE_W-1:0]         lane_mbps_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      err_o,
   output logic [RATE_W-1:0]         rate_code_o,
   output logic [INT_W+FRAC_W-1:0]   fb_div_o
);
   import pllcfg_pkg::*;

   localparam int STEP     = REF_MHZ * FB_MULT;
   localparam int VCO_SPAN = (VCO_MAX > 2 * VCO_MIN) ? VCO_MAX : 2 * VCO_MIN;
   localparam int VCO_W    = $clog2(VCO_SPAN + 1);
   localparam int DIVD_W   = VCO_W + FRAC_W;
   localparam int WORD_W   = INT_W + FRAC_W;
   localparam logic [LANE_W-1:0] LANE_CEIL = LANE_W'(VCO_MAX);

   if (VCO_MIN < 1 || VCO_MIN > VCO_MAX) begin : g_bad_window
      $error("VCO window is empty");
   end
   if (MAX_RATE >= (1 << RATE_W)) begin : g_bad_rate
      $error("rate code field too narrow");
   end
   if ((VCO_MAX / STEP) >= (1 << INT_W)) begin : g_bad_int
      $error("integer field too narrow");
   end
   if ((STEP / 2) >= (1 << FRAC_W)) begin : g_bad_bias
      $error("rounding bias overflows the fraction");
   end
   if (VCO_MAX >= (1 << LANE_W)) begin : g_bad_lane
      $error("lane input cannot express the VCO ceiling");
   end

   calc_state_e       state_q;
   logic              req_bad;
   logic              srch_load, srch_step, div_load;
   logic [VCO_W-1:0]  vco;
   logic [RATE_W-1:0] rate;
   logic              reached, exhausted;
   logic [DIVD_W-1:0] bias;
   logic [DIVD_W-1:0] dividend;
   logic [WORD_W-1:0] quot;
   logic              div_fin;

   // Fraction rounding variant: half-step bias rounds to nearest.
   if (ROUND_NEAREST) begin : g_round_near
      assign bias = DIVD_W'(STEP / 2);
   end else begin : g_round_trunc
      assign bias = '0;
   end

   assign req_bad   = (lane_mbps_i == '0) || (lane_mbps_i > LANE_CEIL);
   assign srch_load = (state_q == ST_IDLE) && start_i && !req_bad;
   assign srch_step = (state_q == ST_SCALE) && !reached && !exhausted;
   assign div_load  = (state_q == ST_SCALE) && reached;
   assign dividend  = {vco, {FRAC_W{1'b0}}} + bias;

   pllcfg_octave_search #(
      .VCO_W    (VCO_W),
      .RATE_W   (RATE_W),
      .VCO_MIN  (VCO_MIN),
      .MAX_RATE (MAX_RATE)
   ) u_search (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (srch_load),
      .step_i      (srch_step),
      .seed_i      (VCO_W'(lane_mbps_i)),
      .vco_o       (vco),
      .rate_o      (rate),
      .reached_o   (reached),
      .exhausted_o (exhausted)
   );

   pllcfg_restoring_div #(
      .DIVD_W  (DIVD_W),
      .DIVISOR (STEP),
      .QUOT_W  (WORD_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (div_load),
      .dividend_i (dividend),
      .quot_o     (quot),
      .fin_o      (div_fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         busy_o      <= 1'b0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
         rate_code_o <= '0;
         fb_div_o    <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (req_bad) begin
                     done_o      <= 1'b1;
                     err_o       <= 1'b1;
                     rate_code_o <= '0;
                     fb_div_o    <= '0;
                  end else begin
                     state_q <= ST_SCALE;
                     busy_o  <= 1'b1;
                  end
               end
            end
            ST_SCALE: begin
               if (reached) begin
                  state_q <= ST_DIVIDE;
               end else if (exhausted) begin
                  state_q     <= ST_IDLE;
                  busy_o      <= 1'b0;
                  done_o      <= 1'b1;
                  err_o       <= 1'b1;
                  rate_code_o <= '0;
                  fb_div_o    <= '0;
               end
            end
            ST_DIVIDE: begin
               if (div_fin) begin
                  state_q     <= ST_IDLE;
                  busy_o      <= 1'b0;
                  done_o      <= 1'b1;
                  err_o       <= 1'b0;
                  rate_code_o <= rate;
                  fb_div_o    <= quot;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pllcfg_checker.sv
module pllcfg_checker #(
   parameter int LANE_W   = 13,
   parameter int RATE_W   = 3,
   parameter int INT_W    = 5,
   parameter int FRAC_W   = 10,
   parameter int MAX_RATE = 4,
   parameter int VCO_MAX  = 4000,
   parameter int INT_CEIL = 20
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [LANE_W-1:0]       lane_mbps_i,
   input logic                    busy_o,
   input logic                    done_o,
   input logic                    err_o,
   input logic [RATE_W-1:0]       rate_code_o,
   input logic [INT_W+FRAC_W-1:0] fb_div_o
);

   localparam logic [LANE_W-1:0] LANE_CEIL = LANE_W'(VCO_MAX);
   localparam logic [RATE_W-1:0] RATE_TOP  = RATE_W'(MAX_RATE);
   localparam logic [INT_W-1:0]  INT_TOP   = INT_W'(INT_CEIL);

   a_r1_zero_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && lane_mbps_i == '0) |=> (done_o && err_o));

   a_r2_high_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && lane_mbps_i > LANE_CEIL) |=> (done_o && err_o));

   a_r3_code_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (rate_code_o <= RATE_TOP));

   a_r4_int_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (fb_div_o[INT_W+FRAC_W-1:FRAC_W] <= INT_TOP));

   a_r5_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (rate_code_o == '0 && fb_div_o == '0));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({err_o, rate_code_o, fb_div_o}));

   a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

endmodule

bind pll_setting_calc pllcfg_checker #(
   .LANE_W   (LANE_W),
   .RATE_W   (RATE_W),
   .INT_W    (INT_W),
   .FRAC_W   (FRAC_W),
   .MAX_RATE (MAX_RATE),
   .VCO_MAX  (VCO_MAX),
   .INT_CEIL (VCO_MAX / (REF_MHZ * FB_MULT))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .lane_mbps_i (lane_mbps_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .rate_code_o (rate_code_o),
   .fb_div_o    (fb_div_o)
);

// File: tb/pll_setting_calc_test.sv
`timescale 1ns/1ps
module pll_setting_calc_test;

   localparam int LANE_W = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [LANE_W-1:0] lane = '0;
   logic              busy, done, err;
   logic [2:0]        rate;
   logic [14:0]       fb;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pll_setting_calc uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .lane_mbps_i (lane),
      .busy_o      (busy),
      .done_o      (done),
      .err_o       (err),
      .rate_code_o (rate),
      .fb_div_o    (fb)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 195000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, act=%0d exp<=195000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Expected result and latency, straight from the requirements.
   task automatic model(input int l, output int e, output int r, output int w, output int lat);
      e = 0; r = 0; w = 0;
      if (l == 0 || l > 4000) begin
         e = 1; lat = 1;
      end else begin
         while (r <= 4 && (l << r) < 1600) r++;
         if (r > 4) begin
            e = 1; r = 0; lat = 6;
         end else begin
            w = ((l << r) * 1024 + 96) / 192;
            lat = r + 25;
         end
      end
   endtask

   task automatic run(input int l, input bit poke);
      int e, r, w, lat, cyc;
      string tag;
      model(l, e, r, w, lat);
      tag = (l == 0) ? "R1" : (l > 4000) ? "R2" : (e != 0) ? "R3" : "R4";
      @(negedge clk);
      lane  = LANE_W'(l);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      cyc = 1;
      if (lat > 1) check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
      while (!done && cyc < 60) begin
         if (poke && cyc == 3) begin
            lane  = '0;
            start = 1'b1;
         end
         @(posedge clk); #1;
         start = 1'b0;
         cyc++;
      end
      check(done && cyc == lat, "R6 latency", cyc, lat);
      check(err == e[0], {tag, " err"}, int'(err), e);
      check(int'(rate) == r, (e != 0) ? "R5 rate zero" : "R3 rate code", int'(rate), r);
      check(int'(fb) == w, (e != 0) ? "R5 word zero" : "R4 divider word", int'(fb), w);
      if (poke) check(!busy, "R8 ignored start left no work", int'(busy), 0);
      @(posedge clk); #1;
      check(!done, "R7 done pulse width", int'(done), 0);
      check(err == e[0] && int'(rate) == r && int'(fb) == w, "R7 hold",
            int'({err, rate, fb}), int'({e[0], r[2:0], w[14:0]}));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(!busy && !done && !err, "R9 reset flags", int'({busy, done, err}), 0);
      check(rate == 3'd0 && fb == 15'd0, "R9 reset outputs", int'({rate, fb}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      run(2000, 1'b1);   // R8: second start mid-run is ignored
      run(0, 1'b0);      // R1
      run(4001, 1'b0);   // R2
      run(8191, 1'b0);   // R2 top code
      run(99, 1'b0);     // R3 just below reach
      run(100, 1'b0);    // R3 smallest accepted, code 4
      run(37, 1'b1);     // R8 poke during a rejected-late request
      for (int l = 1; l <= 4100; l++) run(l, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule